// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Extension

This block is the arithmetic and logic stage of a 32-bit load-store integer core. It is purely combinational: in the cycle that a decoded instruction reaches it, it receives the instruction format, the opcode and function fields, the constant shift amount, two register operands and a 16-bit immediate. From these it returns a 32-bit result and a signed-overflow flag. The surrounding pipeline registers its inputs and outputs. Any exception raised on overflow belongs to the core, not to this block.

Register-format instructions select their operation through the function field. Immediate-format instructions select it through the opcode. For immediate forms, the immediate takes the place of the second register operand. It is widened by sign replication for arithmetic and compare forms, and by zero fill for logical forms. A single adder serves add, subtract and both compare forms. The adder's carry and overflow terms produce the unsigned and signed less-than answers.

The decoder outputs one operation kind from this set: none, add, subtract, and, or, nor, signed-less, unsigned-less, shift-left, shift-right. It also outputs an operand source (register, sign-extended, zero-extended) and an overflow-enable bit. The result multiplexer is a unique case over the operation kind. There is no clocked state.

Top module: `int_alu_exec`

## Requirements
- R1: With `fmt_imm`=0 and `opcode`=6'h00, function 6'h20 (checked add) and 6'h21 (unchecked add) return rs+rt modulo 2^32. With `fmt_imm`=1, opcode 6'h08 (checked) and 6'h09 (unchecked) return rs plus the widened immediate.
- R2: Function 6'h22 (checked) and 6'h23 (unchecked) return rs minus rt, computed as rs plus the two's complement of rt.
- R3: `ovf` is 1 only for functions 6'h20/6'h22 and opcode 6'h08, and only when the two addends (rt inverted for subtract) share a sign that the result does not. It is 0 for every other instruction, including the unchecked forms.
- R4: Function 6'h26 returns rs AND rt, 6'h25 returns rs OR rt, and 6'h24 returns the inverse of (rs OR rt). With rt=0, 6'h24 therefore gives the bitwise NOT of rs.
- R5: Function 6'h2A (signed) and 6'h2B (unsigned) return 1 when rs < rt and 0 otherwise. Example: rs=0xFFFFFFFF, rt=1 gives 1 for the signed form and 0 for the unsigned form. The answer stays correct when rs-rt overflows.
- R6: Opcodes 6'h08, 6'h09, 6'h0A (signed compare) and 6'h0B (unsigned compare) widen the immediate by copying bit 15 into bits 31..16. The two compare opcodes follow R5 with this widened value as rt.
- R7: Opcode 6'h0C (and) and 6'h0D (or) widen the immediate with zeros. For example, andi with 0xFF00 always clears bits 31..16.
- R8: Function 6'h00 shifts rt left and 6'h02 shifts rt right by `shamt` places, both filling vacated bits with 0. The `shamt` input has no effect on any other instruction.
- R9: An unsupported function code, an unsupported opcode, a nonzero opcode with `fmt_imm`=0, or opcode 6'h00 with `fmt_imm`=1 gives `result`=0 and `ovf`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fmt_imm | input | 1 | 1 = immediate format, 0 = register format |
| opcode | input | 6 | Major operation code |
| funct | input | 6 | Function code for register format |
| shamt | input | 5 | Constant shift distance |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand / shift source |
| imm16 | input | 16 | Instruction immediate |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of checked add/subtract |

## Verification
The signed compare and the overflow detector share one subtraction, so both are active in the same evaluation whenever a compare's internal difference overflows. The bench provokes this with rs=0x7FFFFFFF against rt=0x80000000, and with the reverse pair, in both the register and the immediate compare forms. It judges that the compare result follows true signed order while `ovf` stays 0. The same operand pairs are also applied to checked subtract, where `ovf` must rise.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ADDIU = 6'h09;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_SLTIU = 6'h0B;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;

    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
    localparam logic [FN_W-1:0] FN_NOR  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_AND  = 6'h26;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
    localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_NOR,
        K_SLT, K_SLTU, K_SLL, K_SRL
    } alu_kind_e;

    typedef enum logic [1:0] {
        B_REG, B_SEXT, B_ZEXT
    } bsrc_e;

    typedef struct packed {
        alu_kind_e kind;
        bsrc_e     bsrc;
        logic      ovf_en;
    } alu_ctl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_exec_pkg::*;
(
    input  logic             fmt_imm,
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output alu_ctl_t         ctl
);

    alu_ctl_t reg_ctl;
    alu_ctl_t imm_ctl;

    // register format: function field picks the operation
    always_comb begin
        reg_ctl = '{kind: K_NONE, bsrc: B_REG, ovf_en: 1'b0};
        unique case (funct)
            FN_ADD:  reg_ctl = '{kind: K_ADD,  bsrc: B_REG, ovf_en: 1'b1};
            FN_ADDU: reg_ctl = '{kind: K_ADD,  bsrc: B_REG, ovf_en: 1'b0};
            FN_SUB:  reg_ctl = '{kind: K_SUB,  bsrc: B_REG, ovf_en: 1'b1};
            FN_SUBU: reg_ctl = '{kind: K_SUB,  bsrc: B_REG, ovf_en: 1'b0};
            FN_AND:  reg_ctl = '{kind: K_AND,  bsrc: B_REG, ovf_en: 1'b0};
            FN_OR:   reg_ctl = '{kind: K_OR,   bsrc: B_REG, ovf_en: 1'b0};
            FN_NOR:  reg_ctl = '{kind: K_NOR,  bsrc: B_REG, ovf_en: 1'b0};
            FN_SLT:  reg_ctl = '{kind: K_SLT,  bsrc: B_REG, ovf_en: 1'b0};
            FN_SLTU: reg_ctl = '{kind: K_SLTU, bsrc: B_REG, ovf_en: 1'b0};
            FN_SLL:  reg_ctl = '{kind: K_SLL,  bsrc: B_REG, ovf_en: 1'b0};
            FN_SRL:  reg_ctl = '{kind: K_SRL,  bsrc: B_REG, ovf_en: 1'b0};
            default: reg_ctl = '{kind: K_NONE, bsrc: B_REG, ovf_en: 1'b0};
        endcase
    end

    // immediate format: opcode picks operation and widening
    always_comb begin
        imm_ctl = '{kind: K_NONE, bsrc: B_REG, ovf_en: 1'b0};
        unique case (opcode)
            OPC_ADDI:  imm_ctl = '{kind: K_ADD,  bsrc: B_SEXT, ovf_en: 1'b1};
            OPC_ADDIU: imm_ctl = '{kind: K_ADD,  bsrc: B_SEXT, ovf_en: 1'b0};
            OPC_SLTI:  imm_ctl = '{kind: K_SLT,  bsrc: B_SEXT, ovf_en: 1'b0};
            OPC_SLTIU: imm_ctl = '{kind: K_SLTU, bsrc: B_SEXT, ovf_en: 1'b0};
            OPC_ANDI:  imm_ctl = '{kind: K_AND,  bsrc: B_ZEXT, ovf_en: 1'b0};
            OPC_ORI:   imm_ctl = '{kind: K_OR,   bsrc: B_ZEXT, ovf_en: 1'b0};
            default:   imm_ctl = '{kind: K_NONE, bsrc: B_REG,  ovf_en: 1'b0};
        endcase
    end

    always_comb begin
        if (fmt_imm) begin
            ctl = imm_ctl;
        end else if (opcode == OPC_REG) begin
            ctl = reg_ctl;
        end else begin
            ctl = '{kind: K_NONE, bsrc: B_REG, ovf_en: 1'b0};
        end
    end

endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    localparam int PAD_W = DATA_W - IMM_W
) (
    input  bsrc_e              bsrc,
    input  logic [DATA_W-1:0]  rt_val,
    input  logic [IMM_W-1:0]   imm,
    output logic [DATA_W-1:0]  b_opnd
);

    logic [DATA_W-1:0] imm_sext;
    logic [DATA_W-1:0] imm_zext;

    assign imm_sext = {{PAD_W{imm[IMM_W-1]}}, imm};
    assign imm_zext = {{PAD_W{1'b0}}, imm};

    always_comb begin
        unique case (bsrc)
            B_SEXT:  b_opnd = imm_sext;
            B_ZEXT:  b_opnd = imm_zext;
            default: b_opnd = rt_val;
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              ovf_raw,
    output logic              less_s,
    output logic              less_u
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    // two's complement subtract: invert and carry in one
    assign b_eff = sub ? ~b : b;
    assign wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    assign sum   = wide[MSB:0];

    assign ovf_raw = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    // signed order corrects the difference sign by overflow
    assign less_s  = sum[MSB] ^ ovf_raw;
    // no carry out of a - b means a borrowed
    assign less_u  = ~wide[DATA_W];

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val,
    input  logic [SH_W-1:0]   amt,
    input  logic              left,
    output logic [DATA_W-1:0] out
);

    logic [DATA_W-1:0] val_rev;
    logic [DATA_W-1:0] res_rev;
    logic [DATA_W-1:0] stage [0:SH_W];

    // left shift reuses the right shifter on a mirrored word
    for (genvar i = 0; i < DATA_W; i++) begin : g_mirror
        assign val_rev[i] = val[DATA_W-1-i];
        assign res_rev[i] = stage[SH_W][DATA_W-1-i];
    end

    assign stage[0] = left ? val_rev : val;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign stage[k+1] = amt[k]
            ? {{DIST{1'b0}}, stage[k][DATA_W-1:DIST]}
            : stage[k];
    end

    assign out = left ? res_rev : stage[SH_W];

endmodule

// File: rtl/int_alu_exec.sv
module int_alu_exec
    import alu_exec_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 16,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               fmt_imm,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FN_W-1:0]    funct,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [DATA_W-1:0]  rs_val,
    input  logic [DATA_W-1:0]  rt_val,
    input  logic [IMM_W-1:0]   imm16,
    output logic [DATA_W-1:0]  result,
    output logic               ovf
);

    alu_ctl_t          ctl;
    logic [DATA_W-1:0] b_opnd;
    logic              do_sub;
    logic [DATA_W-1:0] sum;
    logic              ovf_raw;
    logic              less_s;
    logic              less_u;
    logic [DATA_W-1:0] shifted;

    alu_decode u_decode (
        .fmt_imm (fmt_imm),
        .opcode  (opcode),
        .funct   (funct),
        .ctl     (ctl)
    );

    alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .bsrc   (ctl.bsrc),
        .rt_val (rt_val),
        .imm    (imm16),
        .b_opnd (b_opnd)
    );

    // compares run through the subtractor
    assign do_sub = (ctl.kind == K_SUB) || (ctl.kind == K_SLT) ||
                    (ctl.kind == K_SLTU);

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a       (rs_val),
        .b       (b_opnd),
        .sub     (do_sub),
        .sum     (sum),
        .ovf_raw (ovf_raw),
        .less_s  (less_s),
        .less_u  (less_u)
    );

    alu_shifter #(.DATA_W(DATA_W)) u_shift (
        .val  (rt_val),
        .amt  (shamt),
        .left (ctl.kind == K_SLL),
        .out  (shifted)
    );

    always_comb begin
        unique case (ctl.kind)
            K_ADD, K_SUB: result = sum;
            K_AND:        result = rs_val & b_opnd;
            K_OR:         result = rs_val | b_opnd;
            K_NOR:        result = ~(rs_val | b_opnd);
            K_SLT:        result = {{(DATA_W-1){1'b0}}, less_s};
            K_SLTU:       result = {{(DATA_W-1){1'b0}}, less_u};
            K_SLL, K_SRL: result = shifted;
            default:      result = '0;
        endcase
    end

    assign ovf = ctl.ovf_en && ovf_raw &&
                 ((ctl.kind == K_ADD) || (ctl.kind == K_SUB));

endmodule

// File: rtl/int_alu_exec_chk.sv
module int_alu_exec_chk
    import alu_exec_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 16,
    localparam int SHAMT_W = $clog2(DATA_W)
) (
    input logic               fmt_imm,
    input logic [OPC_W-1:0]   opcode,
    input logic [FN_W-1:0]    funct,
    input logic [SHAMT_W-1:0] shamt,
    input logic [DATA_W-1:0]  rs_val,
    input logic [DATA_W-1:0]  rt_val,
    input logic [IMM_W-1:0]   imm16,
    input logic [DATA_W-1:0]  result,
    input logic               ovf
);

    localparam int HI_W = DATA_W - IMM_W;

    logic is_reg, is_imm;
    logic f_chk, f_nor, f_cmp, f_sll, f_srl, f_addu;
    logic o_addi, o_cmp, o_andi, o_ori;
    logic known;
    logic [DATA_W-1:0] low_mask;

    always_comb begin
        is_reg = !fmt_imm && (opcode == OPC_REG);
        is_imm = fmt_imm;
        f_chk  = is_reg && ((funct == FN_ADD) || (funct == FN_SUB));
        f_addu = is_reg && (funct == FN_ADDU);
        f_nor  = is_reg && (funct == FN_NOR);
        f_cmp  = is_reg && ((funct == FN_SLT) || (funct == FN_SLTU));
        f_sll  = is_reg && (funct == FN_SLL);
        f_srl  = is_reg && (funct == FN_SRL);
        o_addi = is_imm && (opcode == OPC_ADDI);
        o_cmp  = is_imm && ((opcode == OPC_SLTI) || (opcode == OPC_SLTIU));
        o_andi = is_imm && (opcode == OPC_ANDI);
        o_ori  = is_imm && (opcode == OPC_ORI);
        known  = (is_reg && (funct inside {FN_SLL, FN_SRL, FN_ADD, FN_ADDU,
                     FN_SUB, FN_SUBU, FN_NOR, FN_OR, FN_AND, FN_SLT, FN_SLTU})) ||
                 (is_imm && (opcode inside {OPC_ADDI, OPC_ADDIU, OPC_SLTI,
                     OPC_SLTIU, OPC_ANDI, OPC_ORI}));
        low_mask = (DATA_W'(1) << shamt) - DATA_W'(1);
    end

    always_comb begin
        assert_no_overflow_R3: assert (!ovf || f_chk || o_addi)
            else $error("overflow flag on an unchecked instruction");
        assert_addu_sum_R1: assert (!f_addu || (result == rs_val + rt_val))
            else $error("unchecked add result wrong");
        assert_nor_R4: assert (!f_nor ||
                (((result & (rs_val | rt_val)) == '0) &&
                 ((result | rs_val | rt_val) == '1)))
            else $error("nor result not complement of or");
        assert_cmp_bool_R5: assert (!(f_cmp || o_cmp) || (result[DATA_W-1:1] == '0))
            else $error("compare result not 0 or 1");
        assert_andi_zext_R7: assert (!o_andi || (result[DATA_W-1:IMM_W] == '0))
            else $error("andi high half not cleared");
        assert_ori_zext_R7: assert (!o_ori ||
                (result[DATA_W-1:IMM_W] == rs_val[DATA_W-1:IMM_W]))
            else $error("ori high half altered");
        assert_sll_fill_R8: assert (!f_sll || ((result & low_mask) == '0))
            else $error("sll vacated bits not zero");
        assert_srl_fill_R8: assert (!f_srl || ((result & ~({DATA_W{1'b1}} >> shamt)) == '0))
            else $error("srl vacated bits not zero");
        assert_unsupported_zero_R9: assert (known || ((result == '0) && !ovf))
            else $error("unsupported code produced output");
        assert_sext_width_R6: assert (HI_W > 0)
            else $error("immediate wider than datapath");
    end

endmodule

bind int_alu_exec int_alu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .fmt_imm (fmt_imm),
    .opcode  (opcode),
    .funct   (funct),
    .shamt   (shamt),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .imm16   (imm16),
    .result  (result),
    .ovf     (ovf)
);

// File: tb/int_alu_exec_bench.sv
module int_alu_exec_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_imm;
    logic [5:0]  opcode;
    logic [5:0]  funct;
    logic [4:0]  shamt;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [15:0] imm16;
    logic [31:0] result;
    logic        ovf;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    int_alu_exec u_int_alu_exec (
        .fmt_imm (fmt_imm),
        .opcode  (opcode),
        .funct   (funct),
        .shamt   (shamt),
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .imm16   (imm16),
        .result  (result),
        .ovf     (ovf)
    );

    // behavioural reference: {ovf, result}
    function automatic logic [32:0] ref_model(logic f, logic [5:0] op, logic [5:0] fn,
            logic [4:0] sh, logic [31:0] a, logic [31:0] b, logic [15:0] im);
        logic [31:0] sx = {{16{im[15]}}, im};
        logic [31:0] zx = {16'h0, im};
        logic [31:0] r;
        logic o = 1'b0;
        r = '0;
        if (!f) begin
            if (op != 6'h00) return '0;
            case (fn)
                6'h20: begin r = a + b; o = (a[31] == b[31]) && (r[31] != a[31]); end
                6'h21: r = a + b;
                6'h22: begin r = a - b; o = (a[31] != b[31]) && (r[31] != a[31]); end
                6'h23: r = a - b;
                6'h24: r = ~(a | b);
                6'h25: r = a | b;
                6'h26: r = a & b;
                6'h2A: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                6'h2B: r = (a < b) ? 32'd1 : 32'd0;
                6'h00: r = b << sh;
                6'h02: r = b >> sh;
                default: r = '0;
            endcase
        end else begin
            case (op)
                6'h08: begin r = a + sx; o = (a[31] == sx[31]) && (r[31] != a[31]); end
                6'h09: r = a + sx;
                6'h0A: r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
                6'h0B: r = (a < sx) ? 32'd1 : 32'd0;
                6'h0C: r = a & zx;
                6'h0D: r = a | zx;
                default: r = '0;
            endcase
        end
        return {o, r};
    endfunction

    task automatic drive(input logic f, input logic [5:0] op, input logic [5:0] fn,
            input logic [4:0] sh, input logic [31:0] a, input logic [31:0] b,
            input logic [15:0] im);
        @(negedge clk);
        fmt_imm = f; opcode = op; funct = fn; shamt = sh;
        rs_val = a; rt_val = b; imm16 = im;
        #2;
    endtask

    task automatic check(input string tag, input logic [31:0] exp_r, input logic exp_o);
        total++;
        if (result !== exp_r || ovf !== exp_o) begin
            bad++;
            $display("FAIL %s: got result=%h ovf=%b exp result=%h ovf=%b",
                     tag, result, ovf, exp_r, exp_o);
        end
    endtask

    task automatic check_model(input string tag);
        logic [32:0] e;
        e = ref_model(fmt_imm, opcode, funct, shamt, rs_val, rt_val, imm16);
        check(tag, e[31:0], e[32]);
    endtask

    task automatic t_reset;
        drive(1'b0, 6'h00, 6'h00, 5'd0, 32'h0, 32'h0, 16'h0);
        check("R8 idle zero", 32'h0, 1'b0);
    endtask

    task automatic t_add;
        drive(1'b0, 6'h00, 6'h20, 5'd0, 32'd7, 32'd9, 16'h0);
        check("R1 add", 32'd16, 1'b0);
        drive(1'b0, 6'h00, 6'h20, 5'd0, 32'h7FFFFFFF, 32'd1, 16'h0);
        check("R3 add overflow", 32'h80000000, 1'b1);
        drive(1'b0, 6'h00, 6'h21, 5'd0, 32'h7FFFFFFF, 32'd1, 16'h0);
        check("R3 addu no flag", 32'h80000000, 1'b0);
        drive(1'b0, 6'h00, 6'h21, 5'd0, 32'hFFFFFFFF, 32'd1, 16'h0);
        check("R1 addu wrap", 32'h0, 1'b0);
        drive(1'b0, 6'h00, 6'h20, 5'd0, 32'h80000000, 32'h80000000, 16'h0);
        check("R3 add neg overflow", 32'h0, 1'b1);
    endtask

    task automatic t_sub;
        drive(1'b0, 6'h00, 6'h22, 5'd0, 32'd5, 32'd9, 16'h0);
        check("R2 sub", 32'hFFFFFFFC, 1'b0);
        drive(1'b0, 6'h00, 6'h23, 5'd0, 32'h0, 32'd2, 16'h0);
        check("R2 subu negate", 32'hFFFFFFFE, 1'b0);
        drive(1'b0, 6'h00, 6'h22, 5'd0, 32'h80000000, 32'd1, 16'h0);
        check("R3 sub overflow", 32'h7FFFFFFF, 1'b1);
        drive(1'b0, 6'h00, 6'h23, 5'd0, 32'h80000000, 32'd1, 16'h0);
        check("R3 subu no flag", 32'h7FFFFFFF, 1'b0);
    endtask

    task automatic t_logic;
        drive(1'b0, 6'h00, 6'h26, 5'd0, 32'h00003C00, 32'h00000DC0, 16'h0);
        check("R4 and", 32'h00000C00, 1'b0);
        drive(1'b0, 6'h00, 6'h25, 5'd0, 32'h00003C00, 32'h00000DC0, 16'h0);
        check("R4 or", 32'h00003DC0, 1'b0);
        drive(1'b0, 6'h00, 6'h24, 5'd0, 32'h00003C00, 32'h0, 16'h0);
        check("R4 nor as not", 32'hFFFFC3FF, 1'b0);
    endtask

    task automatic t_compare;
        drive(1'b0, 6'h00, 6'h2A, 5'd0, 32'hFFFFFFFF, 32'd1, 16'h0);
        check("R5 slt signed", 32'd1, 1'b0);
        drive(1'b0, 6'h00, 6'h2B, 5'd0, 32'hFFFFFFFF, 32'd1, 16'h0);
        check("R5 sltu unsigned", 32'd0, 1'b0);
        drive(1'b0, 6'h00, 6'h2A, 5'd0, 32'd4, 32'd4, 16'h0);
        check("R5 slt equal", 32'd0, 1'b0);
    endtask

    // compare and overflow share one subtraction
    task automatic t_compare_overflow;
        drive(1'b0, 6'h00, 6'h2A, 5'd0, 32'h7FFFFFFF, 32'h80000000, 16'h0);
        check("R5 slt on overflowing diff", 32'd0, 1'b0);
        drive(1'b0, 6'h00, 6'h2A, 5'd0, 32'h80000000, 32'h7FFFFFFF, 16'h0);
        check("R5 slt on overflowing diff rev", 32'd1, 1'b0);
        drive(1'b0, 6'h00, 6'h2B, 5'd0, 32'h7FFFFFFF, 32'h80000000, 16'h0);
        check("R5 sltu on same pair", 32'd1, 1'b0);
        drive(1'b0, 6'h00, 6'h22, 5'd0, 32'h7FFFFFFF, 32'h80000000, 16'h0);
        check("R3 sub same pair flags", 32'hFFFFFFFF, 1'b1);
        drive(1'b1, 6'h0A, 6'h00, 5'd0, 32'h7FFFFFFF, 32'h0, 16'h8000);
        check("R6 slti on overflowing diff", 32'd0, 1'b0);
    endtask

    task automatic t_imm_sext;
        drive(1'b1, 6'h08, 6'h00, 5'd0, 32'd5, 32'h0, 16'hFFFF);
        check("R6 addi minus one", 32'd4, 1'b0);
        drive(1'b1, 6'h08, 6'h00, 5'd0, 32'h7FFFFFFF, 32'h0, 16'h0001);
        check("R3 addi overflow", 32'h80000000, 1'b1);
        drive(1'b1, 6'h09, 6'h00, 5'd0, 32'h7FFFFFFF, 32'h0, 16'h0001);
        check("R3 addiu no flag", 32'h80000000, 1'b0);
        drive(1'b1, 6'h0A, 6'h00, 5'd0, 32'hFFFFFFFE, 32'h0, 16'hFFFF);
        check("R6 slti sext", 32'd1, 1'b0);
        drive(1'b1, 6'h0B, 6'h00, 5'd0, 32'h0000FFFF, 32'h0, 16'hFFFF);
        check("R6 sltiu sext", 32'd1, 1'b0);
    endtask

    task automatic t_imm_zext;
        drive(1'b1, 6'h0C, 6'h00, 5'd0, 32'hFFFFFFFF, 32'h0, 16'hFF00);
        check("R7 andi zext", 32'h0000FF00, 1'b0);
        drive(1'b1, 6'h0D, 6'h00, 5'd0, 32'h12340000, 32'h0, 16'h8001);
        check("R7 ori zext", 32'h12348001, 1'b0);
    endtask

    task automatic t_shift;
        drive(1'b0, 6'h00, 6'h00, 5'd31, 32'h0, 32'd1, 16'h0);
        check("R8 sll 31", 32'h80000000, 1'b0);
        drive(1'b0, 6'h00, 6'h02, 5'd31, 32'h0, 32'h80000000, 16'h0);
        check("R8 srl 31", 32'd1, 1'b0);
        drive(1'b0, 6'h00, 6'h02, 5'd4, 32'h0, 32'hF0000000, 16'h0);
        check("R8 srl zero fill", 32'h0F000000, 1'b0);
        drive(1'b0, 6'h00, 6'h00, 5'd8, 32'h0, 32'h00A5A5FF, 16'h0);
        check("R8 sll 8", 32'hA5A5FF00, 1'b0);
        drive(1'b0, 6'h00, 6'h21, 5'd17, 32'd3, 32'd4, 16'h0);
        check("R8 shamt ignored by addu", 32'd7, 1'b0);
    endtask

    task automatic t_unsupported;
        drive(1'b0, 6'h00, 6'h3F, 5'd3, 32'h7FFFFFFF, 32'd1, 16'h0);
        check("R9 bad funct", 32'h0, 1'b0);
        drive(1'b0, 6'h08, 6'h20, 5'd0, 32'h7FFFFFFF, 32'd1, 16'h0001);
        check("R9 reg fmt nonzero opcode", 32'h0, 1'b0);
        drive(1'b1, 6'h00, 6'h20, 5'd0, 32'h7FFFFFFF, 32'd1, 16'h0001);
        check("R9 imm fmt opcode zero", 32'h0, 1'b0);
        drive(1'b1, 6'h23, 6'h00, 5'd0, 32'hFFFFFFFF, 32'd1, 16'hFFFF);
        check("R9 bad opcode", 32'h0, 1'b0);
    endtask

    task automatic t_corners;
        logic [31:0] cv [4] = '{32'h0, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000};
        logic [5:0]  fns [11] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25,
                                  6'h26, 6'h2A, 6'h2B, 6'h00, 6'h02};
        logic [5:0]  ops [6] = '{6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D};
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                for (int k = 0; k < 11; k++) begin
                    drive(1'b0, 6'h00, fns[k], cv[j][4:0], cv[i], cv[j], 16'h0);
                    check_model("R1-corner reg-form model R2 R4 R5");
                end
                for (int k = 0; k < 6; k++) begin
                    drive(1'b1, ops[k], 6'h00, 5'd0, cv[i], 32'h0, cv[j][31:16]);
                    check_model("R6 R7 corner imm-form model");
                end
            end
        end
    endtask

    task automatic t_random;
        logic [5:0] fns [11] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25,
                                 6'h26, 6'h2A, 6'h2B, 6'h00, 6'h02};
        logic [5:0] ops [6] = '{6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D};
        for (int n = 0; n < 2000; n++) begin
            if (n % 2 == 0)
                drive(1'b0, 6'h00, fns[$urandom_range(10)], 5'($urandom),
                      $urandom, $urandom, 16'($urandom));
            else
                drive(1'b1, ops[$urandom_range(5)], 6'($urandom), 5'($urandom),
                      $urandom, $urandom, 16'($urandom));
            check_model("R1 R3 random model");
        end
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog R9 run: got no finish, exp finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        fmt_imm = 1'b0; opcode = '0; funct = '0; shamt = '0;
        rs_val = '0; rt_val = '0; imm16 = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_compare();
        t_compare_overflow();
        t_imm_sext();
        t_imm_zext();
        t_shift();
        t_unsupported();
        t_corners();
        t_random();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule